// File: doc/BRIEF.md
# Exception Entry Unit

This block performs the register side of taking an exception in a pipelined processor's system-control coprocessor. It receives a single-cycle request with an exception kind, the faulting PC and the PC that would have followed it, a faulting address, an address-space id and a coprocessor number. In the same clock edge it updates the status, cause, exception-PC, bad-address, TLB-entry-high, page-context and shadow-set control registers. One cycle later it presents a redirect pulse with the handler fetch address and the two PCs that follow it.

A soft reset input forces the fetch PCs to the reset vector and marks coprocessor 1 usable. A simple select/write/read port gives software access to all eight registers. Decode, TLB lookup, the flush and the return-from-exception path are handled elsewhere.

Top module: `exc_entry_unit`

## Requirements
- R1: When status EXL (bit 1) and BEV (bit 22) are both 0 at entry, the shadow control register takes its current-set field [3:0] into the previous-set field [9:6] and its exception-set field [15:12] into the current-set field. Otherwise the register does not change.
- R2: Every exception entry leaves status EXL at 1, whether or not it was set before.
- R3: If the next PC differs from PC+4, the exception PC register takes PC-4 and cause bit 31 (delay slot) is set. Otherwise it takes PC and bit 31 is cleared.
- R4: Entry writes the cause code field [6:2] and clears the coprocessor field [29:28]. For the coprocessor-unusable kind, that field takes the coprocessor number instead. The interrupt-vector bit 23 is kept.
- R5: exc_kind_i encodings map to cause codes as follows. 0 interrupt→0x0, 1 TLB modified→0x1, 2 TLB refill load→0x2, 3 TLB refill store→0x3, 4 TLB invalid load→0x2, 5 TLB invalid store→0x3, 6 address error load→0x4, 7 address error store→0x5, 8 syscall→0x8, 9 breakpoint→0x9, 10 reserved instruction→0xA, 11 coprocessor unusable→0xB, 12 overflow→0xC, 13 trap→0xD. The unused values 14 and 15 behave like 10.
- R6: General exceptions vector to base+0x180. Overflow taken with BEV=1 vectors to the fixed address 0xBFC00200. Other kinds ignore BEV.
- R7: A TLB refill vectors to base+0x000 if EXL was 0 before the entry, and to base+0x180 if EXL was already 1.
- R8: An interrupt vectors to base+0x200 when cause bit 23 is 1, and to base+0x180 otherwise.
- R9: One cycle after a request, redirect_o is 1 for exactly one cycle. The fetch PC outputs are then the handler address, +4 and +8.
- R10: Address-error and all TLB kinds load the faulting address into the bad-address register. The TLB kinds also put address bits [31:13] into TLB-entry-high [31:13] with the id in [7:0], and into the context field [22:4]. No other kind touches these three registers.
- R11: A soft reset has priority over a same-cycle exception. It drives the fetch PCs to 0xBFC00000, +4 and +8, sets status bits 29 and 22, and performs no exception update.
- R12: After rst_ni, status reads 0x20400000, the base reads 0x80000000, the other registers read 0, the fetch PC is 0xBFC00000 and redirect_o is 0.
- R13: csr_sel_i selects 0 status, 1 cause, 2 exception PC, 3 bad address, 4 TLB entry high, 5 context, 6 shadow control, 7 base. Writes land on the next edge, and the base ignores write bits [11:0]. An exception in the same cycle overrides a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| exc_valid_i | input | 1 | Exception request, one cycle |
| exc_kind_i | input | 4 | Exception kind (R5 encoding) |
| pc_i | input | 32 | PC of faulting instruction |
| npc_i | input | 32 | PC that would have followed |
| bad_addr_i | input | 32 | Faulting virtual address |
| asid_i | input | 8 | Address-space id of the access |
| cop_id_i | input | 2 | Coprocessor number for unusable fault |
| soft_rst_i | input | 1 | Soft reset request |
| csr_we_i | input | 1 | Register write enable |
| csr_sel_i | input | 3 | Register select |
| csr_wdata_i | input | 32 | Register write data |
| csr_rdata_o | output | 32 | Selected register value |
| redirect_o | output | 1 | Fetch redirect pulse |
| fetch_pc_o | output | 32 | Handler or reset address |
| fetch_npc_o | output | 32 | Following PC |
| fetch_nnpc_o | output | 32 | PC after that |

## Verification
On every cycle, the assertions check the rules that involve one request and its next cycle. These are that EXL is set, that the exception PC and delay flag match the PC pair, that the shadow control holds when EXL or BEV blocks the swap, that the refill vector follows the prior EXL, that the fetch PCs are spaced by four, and that soft reset redirects to the reset vector. Other behaviour needs scenarios from the bench: the full kind-to-code and vector map under each setting of EXL, BEV and the interrupt-vector bit, the swap values, the coprocessor field, the TLB register contents and their absence for other kinds, and the priority among soft reset, exception and register write.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  typedef enum logic [3:0] {
    K_INT = 4'd0, K_TLB_MOD = 4'd1, K_REFILL_LD = 4'd2, K_REFILL_ST = 4'd3,
    K_INV_LD = 4'd4, K_INV_ST = 4'd5, K_ADDR_LD = 4'd6, K_ADDR_ST = 4'd7,
    K_SYSCALL = 4'd8, K_BREAK = 4'd9, K_RESV = 4'd10, K_COP = 4'd11,
    K_OVF = 4'd12, K_TRAP = 4'd13
  } exc_kind_e;

  typedef enum logic [2:0] {
    S_STATUS = 3'd0, S_CAUSE = 3'd1, S_EPC = 3'd2, S_BADVA = 3'd3,
    S_ENTRYHI = 3'd4, S_CONTEXT = 3'd5, S_SHADOW = 3'd6, S_BASE = 3'd7
  } csr_sel_e;

  localparam int ST_EXL = 1;
  localparam int ST_BEV = 22;
  localparam int ST_CU1 = 29;
  localparam int CA_CODE_LO = 2;
  localparam int CA_IV = 23;
  localparam int CA_CE_LO = 28;
  localparam int CA_BD = 31;
  localparam int SS_W = 4;
  localparam int SS_CUR_LO = 0;
  localparam int SS_PREV_LO = 6;
  localparam int SS_EXC_LO = 12;
  localparam int VPN_LO = 13;
  localparam int ASID_W = 8;
  localparam int CTX_LO = 4;
  localparam int BASE_ALIGN = 12;

  function automatic logic [4:0] kind_code(exc_kind_e k);
    case (k)
      K_INT:                 return 5'h00;
      K_TLB_MOD:             return 5'h01;
      K_REFILL_LD, K_INV_LD: return 5'h02;
      K_REFILL_ST, K_INV_ST: return 5'h03;
      K_ADDR_LD:             return 5'h04;
      K_ADDR_ST:             return 5'h05;
      K_SYSCALL:             return 5'h08;
      K_BREAK:               return 5'h09;
      K_COP:                 return 5'h0B;
      K_OVF:                 return 5'h0C;
      K_TRAP:                return 5'h0D;
      default:               return 5'h0A;
    endcase
  endfunction

  function automatic logic is_tlb(exc_kind_e k);
    return k inside {K_TLB_MOD, K_REFILL_LD, K_REFILL_ST, K_INV_LD, K_INV_ST};
  endfunction

  function automatic logic keeps_addr(exc_kind_e k);
    return is_tlb(k) || k == K_ADDR_LD || k == K_ADDR_ST;
  endfunction
endpackage

// File: rtl/exc_vector_sel.sv
module exc_vector_sel
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] BEV_OV_VEC = 32'hBFC0_0200,
  parameter int OFF_GEN = 'h180,
  parameter int OFF_INT = 'h200
) (
  input  exc_kind_e       kind_i,
  input  logic            exl_i,
  input  logic            bev_i,
  input  logic            iv_i,
  input  logic [XLEN-1:0] base_i,
  output logic [XLEN-1:0] handler_o
);
  localparam logic [XLEN-1:0] GEN_OFS = XLEN'(OFF_GEN);
  localparam logic [XLEN-1:0] INT_OFS = XLEN'(OFF_INT);

  logic [XLEN-1:0] gen_vec;
  assign gen_vec = base_i + GEN_OFS;

  always_comb begin
    case (kind_i)
      K_INT:                    handler_o = iv_i ? base_i + INT_OFS : gen_vec;
      K_REFILL_LD, K_REFILL_ST: handler_o = exl_i ? gen_vec : base_i;
      K_OVF:                    handler_o = bev_i ? BEV_OV_VEC : gen_vec;
      default:                  handler_o = gen_vec;
    endcase
  end
endmodule

// File: rtl/exc_csr_file.sv
module exc_csr_file
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] BASE_RST = 32'h8000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            srst_i,
  input  exc_kind_e       kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] bad_addr_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic [1:0]      cop_id_i,
  input  logic            we_i,
  input  csr_sel_e        sel_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] cause_o,
  output logic [XLEN-1:0] base_o
);
  localparam int VPN_W = XLEN - VPN_LO;
  localparam logic [XLEN-1:0] WORD = XLEN'(4);
  localparam logic [XLEN-1:0] ST_RST = (XLEN'(1) << ST_CU1) | (XLEN'(1) << ST_BEV);

  logic [XLEN-1:0] status_q, cause_q, epc_q, badva_q, entryhi_q, context_q, shadow_q, base_q;
  logic [XLEN-1:0] cause_nxt, epc_nxt, shadow_nxt, entryhi_nxt, context_nxt;
  logic            in_slot;

  always_comb begin
    in_slot = npc_i != pc_i + WORD;
    epc_nxt = in_slot ? pc_i - WORD : pc_i;

    cause_nxt = cause_q;
    cause_nxt[CA_CODE_LO +: 5] = kind_code(kind_i);
    cause_nxt[CA_BD] = in_slot;
    cause_nxt[CA_CE_LO +: 2] = (kind_i == K_COP) ? cop_id_i : 2'b00;

    shadow_nxt = shadow_q;
    if (!status_q[ST_EXL] && !status_q[ST_BEV]) begin
      shadow_nxt[SS_PREV_LO +: SS_W] = shadow_q[SS_CUR_LO +: SS_W];
      shadow_nxt[SS_CUR_LO +: SS_W]  = shadow_q[SS_EXC_LO +: SS_W];
    end

    entryhi_nxt = entryhi_q;
    entryhi_nxt[XLEN-1:VPN_LO] = bad_addr_i[XLEN-1:VPN_LO];
    entryhi_nxt[ASID_W-1:0] = asid_i;

    context_nxt = context_q;
    context_nxt[CTX_LO +: VPN_W] = bad_addr_i[XLEN-1:VPN_LO];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q  <= ST_RST;
      cause_q   <= '0;
      epc_q     <= '0;
      badva_q   <= '0;
      entryhi_q <= '0;
      context_q <= '0;
      shadow_q  <= '0;
      base_q    <= BASE_RST;
    end else if (srst_i) begin
      status_q <= status_q | ST_RST;
    end else if (take_i) begin
      status_q[ST_EXL] <= 1'b1;
      cause_q  <= cause_nxt;
      epc_q    <= epc_nxt;
      shadow_q <= shadow_nxt;
      if (keeps_addr(kind_i)) badva_q <= bad_addr_i;
      if (is_tlb(kind_i)) begin
        entryhi_q <= entryhi_nxt;
        context_q <= context_nxt;
      end
    end else if (we_i) begin
      case (sel_i)
        S_STATUS:  status_q  <= wdata_i;
        S_CAUSE:   cause_q   <= wdata_i;
        S_EPC:     epc_q     <= wdata_i;
        S_BADVA:   badva_q   <= wdata_i;
        S_ENTRYHI: entryhi_q <= wdata_i;
        S_CONTEXT: context_q <= wdata_i;
        S_SHADOW:  shadow_q  <= wdata_i;
        default:   base_q    <= {wdata_i[XLEN-1:BASE_ALIGN], BASE_ALIGN'(0)};
      endcase
    end
  end

  always_comb begin
    case (sel_i)
      S_STATUS:  rdata_o = status_q;
      S_CAUSE:   rdata_o = cause_q;
      S_EPC:     rdata_o = epc_q;
      S_BADVA:   rdata_o = badva_q;
      S_ENTRYHI: rdata_o = entryhi_q;
      S_CONTEXT: rdata_o = context_q;
      S_SHADOW:  rdata_o = shadow_q;
      default:   rdata_o = base_q;
    endcase
  end

  assign status_o = status_q;
  assign cause_o  = cause_q;
  assign base_o   = base_q;
endmodule

// File: rtl/exc_pc_redirect.sv
module exc_pc_redirect #(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            take_i,
  input  logic            srst_i,
  input  logic [XLEN-1:0] handler_i,
  output logic            redirect_o,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o,
  output logic [XLEN-1:0] nnpc_o
);
  localparam logic [XLEN-1:0] WORD = XLEN'(4);

  logic [XLEN-1:0] target;
  assign target = srst_i ? RESET_VEC : handler_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      redirect_o <= 1'b0;
      pc_o       <= RESET_VEC;
      npc_o      <= RESET_VEC + WORD;
      nnpc_o     <= RESET_VEC + 2 * WORD;
    end else begin
      redirect_o <= srst_i || take_i;
      if (srst_i || take_i) begin
        pc_o   <= target;
        npc_o  <= target + WORD;
        nnpc_o <= target + 2 * WORD;
      end
    end
  end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC  = 32'hBFC0_0000,
  parameter logic [XLEN-1:0] BEV_OV_VEC = 32'hBFC0_0200,
  parameter logic [XLEN-1:0] BASE_RST   = 32'h8000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            exc_valid_i,
  input  logic [3:0]      exc_kind_i,
  input  logic [XLEN-1:0] pc_i,
  input  logic [XLEN-1:0] npc_i,
  input  logic [XLEN-1:0] bad_addr_i,
  input  logic [7:0]      asid_i,
  input  logic [1:0]      cop_id_i,
  input  logic            soft_rst_i,
  input  logic            csr_we_i,
  input  logic [2:0]      csr_sel_i,
  input  logic [XLEN-1:0] csr_wdata_i,
  output logic [XLEN-1:0] csr_rdata_o,
  output logic            redirect_o,
  output logic [XLEN-1:0] fetch_pc_o,
  output logic [XLEN-1:0] fetch_npc_o,
  output logic [XLEN-1:0] fetch_nnpc_o
);
  exc_kind_e       kind;
  logic            take;
  logic [XLEN-1:0] status_q, cause_q, base_q, handler;

  assign kind = exc_kind_e'(exc_kind_i);
  assign take = exc_valid_i && !soft_rst_i;

  exc_csr_file #(.XLEN(XLEN), .BASE_RST(BASE_RST)) u_csr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .srst_i     (soft_rst_i),
    .kind_i     (kind),
    .pc_i       (pc_i),
    .npc_i      (npc_i),
    .bad_addr_i (bad_addr_i),
    .asid_i     (asid_i),
    .cop_id_i   (cop_id_i),
    .we_i       (csr_we_i),
    .sel_i      (csr_sel_e'(csr_sel_i)),
    .wdata_i    (csr_wdata_i),
    .rdata_o    (csr_rdata_o),
    .status_o   (status_q),
    .cause_o    (cause_q),
    .base_o     (base_q)
  );

  // Uses register state from before the entry edge (prior EXL for refills).
  exc_vector_sel #(.XLEN(XLEN), .BEV_OV_VEC(BEV_OV_VEC)) u_vec (
    .kind_i    (kind),
    .exl_i     (status_q[ST_EXL]),
    .bev_i     (status_q[ST_BEV]),
    .iv_i      (cause_q[CA_IV]),
    .base_i    (base_q),
    .handler_o (handler)
  );

  exc_pc_redirect #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_pc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .take_i     (take),
    .srst_i     (soft_rst_i),
    .handler_i  (handler),
    .redirect_o (redirect_o),
    .pc_o       (fetch_pc_o),
    .npc_o      (fetch_npc_o),
    .nnpc_o     (fetch_nnpc_o)
  );
endmodule

// File: rtl/exc_entry_unit_chk.sv
module exc_entry_unit_chk
  import exc_entry_pkg::*;
#(
  parameter int XLEN = 32,
  parameter logic [XLEN-1:0] RESET_VEC = 32'hBFC0_0000
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            exc_valid_i,
  input logic            soft_rst_i,
  input logic [3:0]      exc_kind_i,
  input logic [XLEN-1:0] pc_i,
  input logic [XLEN-1:0] npc_i,
  input logic [XLEN-1:0] status_q,
  input logic [XLEN-1:0] cause_q,
  input logic [XLEN-1:0] epc_q,
  input logic [XLEN-1:0] shadow_q,
  input logic [XLEN-1:0] base_q,
  input logic            redirect_o,
  input logic [XLEN-1:0] fetch_pc_o,
  input logic [XLEN-1:0] fetch_npc_o,
  input logic [XLEN-1:0] fetch_nnpc_o
);
  logic chk_take, chk_refill;
  assign chk_take   = exc_valid_i && !soft_rst_i;
  assign chk_refill = exc_kind_i == K_REFILL_LD || exc_kind_i == K_REFILL_ST;

  p_exl_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take |=> status_q[ST_EXL]);

  p_epc_plain_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take && npc_i == pc_i + 32'd4 |=> epc_q == $past(pc_i) && !cause_q[CA_BD]);

  p_epc_slot_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take && npc_i != pc_i + 32'd4 |=> epc_q == $past(pc_i) - 32'd4 && cause_q[CA_BD]);

  p_shadow_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take && (status_q[ST_EXL] || status_q[ST_BEV]) |=> $stable(shadow_q));

  p_refill_vec_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_take && chk_refill && !status_q[ST_EXL] |=> fetch_pc_o == $past(base_q));

  p_pc_step_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    redirect_o |-> fetch_npc_o == fetch_pc_o + 32'd4 && fetch_nnpc_o == fetch_pc_o + 32'd8);

  p_soft_rst_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> redirect_o && fetch_pc_o == RESET_VEC);
endmodule

bind exc_entry_unit exc_entry_unit_chk #(.XLEN(XLEN), .RESET_VEC(RESET_VEC)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .exc_valid_i  (exc_valid_i),
  .soft_rst_i   (soft_rst_i),
  .exc_kind_i   (exc_kind_i),
  .pc_i         (pc_i),
  .npc_i        (npc_i),
  .status_q     (status_q),
  .cause_q      (cause_q),
  .epc_q        (u_csr.epc_q),
  .shadow_q     (u_csr.shadow_q),
  .base_q       (base_q),
  .redirect_o   (redirect_o),
  .fetch_pc_o   (fetch_pc_o),
  .fetch_npc_o  (fetch_npc_o),
  .fetch_nnpc_o (fetch_nnpc_o)
);

// File: tb/exc_entry_unit_bench.sv
`timescale 1ns/1ps
module exc_entry_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        exc_valid = 1'b0;
  logic [3:0]  exc_kind = '0;
  logic [31:0] pc = '0, npc = '0, bad_addr = '0, wdata = '0;
  logic [7:0]  asid = '0;
  logic [1:0]  cop_id = '0;
  logic        soft_rst = 1'b0, we = 1'b0;
  logic [2:0]  sel = '0;
  logic [31:0] rdata, fpc, fnpc, fnnpc;
  logic        redirect;
  int          n_chk = 0, n_bad = 0;
  logic        done = 1'b0;

  always #2 clk = ~clk;

  exc_entry_unit u_exc_entry_unit (
    .clk_i(clk), .rst_ni(rst_n), .exc_valid_i(exc_valid), .exc_kind_i(exc_kind),
    .pc_i(pc), .npc_i(npc), .bad_addr_i(bad_addr), .asid_i(asid), .cop_id_i(cop_id),
    .soft_rst_i(soft_rst), .csr_we_i(we), .csr_sel_i(sel), .csr_wdata_i(wdata),
    .csr_rdata_o(rdata), .redirect_o(redirect), .fetch_pc_o(fpc),
    .fetch_npc_o(fnpc), .fetch_nnpc_o(fnnpc)
  );

  // kind, exl, bev, iv, slot, expected code, expected vector
  localparam logic [44:0] TBL [14] = '{
    {4'd0,  1'b0, 1'b0, 1'b0, 1'b0, 5'h00, 32'h8000_0180},
    {4'd0,  1'b0, 1'b0, 1'b1, 1'b0, 5'h00, 32'h8000_0200},
    {4'd2,  1'b0, 1'b0, 1'b0, 1'b0, 5'h02, 32'h8000_0000},
    {4'd3,  1'b1, 1'b0, 1'b0, 1'b0, 5'h03, 32'h8000_0180},
    {4'd4,  1'b0, 1'b0, 1'b0, 1'b1, 5'h02, 32'h8000_0180},
    {4'd1,  1'b0, 1'b0, 1'b0, 1'b0, 5'h01, 32'h8000_0180},
    {4'd7,  1'b0, 1'b0, 1'b0, 1'b0, 5'h05, 32'h8000_0180},
    {4'd12, 1'b0, 1'b0, 1'b0, 1'b0, 5'h0C, 32'h8000_0180},
    {4'd12, 1'b0, 1'b1, 1'b0, 1'b0, 5'h0C, 32'hBFC0_0200},
    {4'd8,  1'b0, 1'b1, 1'b0, 1'b0, 5'h08, 32'h8000_0180},
    {4'd13, 1'b0, 1'b0, 1'b0, 1'b1, 5'h0D, 32'h8000_0180},
    {4'd9,  1'b0, 1'b0, 1'b0, 1'b0, 5'h09, 32'h8000_0180},
    {4'd10, 1'b0, 1'b0, 1'b0, 1'b0, 5'h0A, 32'h8000_0180},
    {4'd6,  1'b1, 1'b0, 1'b0, 1'b0, 5'h04, 32'h8000_0180}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; sel = s; wdata = d;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] d);
    sel = s;
    #0.1;
    d = rdata;
  endtask

  task automatic take(input logic [3:0] k, input logic [31:0] p, input logic [31:0] np,
                      input logic [31:0] ba, input logic [7:0] id, input logic [1:0] cp);
    @(negedge clk);
    exc_valid = 1'b1; exc_kind = k; pc = p; npc = np; bad_addr = ba; asid = id; cop_id = cp;
    @(negedge clk);
    exc_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL R9 watchdog: actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12 reset state
    rd(3'd0, v); chk("R12 status", v, 32'h2040_0000);
    rd(3'd7, v); chk("R12 base", v, 32'h8000_0000);
    rd(3'd2, v); chk("R12 epc", v, 32'h0);
    chk("R12 fetch pc", fpc, 32'hBFC0_0000);
    chk("R12 redirect", {31'd0, redirect}, 32'h0);

    for (int i = 0; i < 14; i++) begin
      logic [44:0] e;
      logic [31:0] p, np;
      string vt;
      e = TBL[i];
      p = 32'h1000 + 32'(i) * 32'd32;
      np = e[37] ? p + 32'd12 : p + 32'd4;
      vt = (e[44:41] == 4'd0) ? "R8 vector" : (e[44:41] inside {4'd2, 4'd3}) ? "R7 vector" : "R6 vector";
      wr(3'd0, {9'd0, e[39], 20'd0, e[40], 1'b0});
      wr(3'd1, {8'd0, e[38], 23'd0});
      take(e[44:41], p, np, 32'h4000_0000 + 32'(i), 8'h11, 2'd1);
      chk(vt, fpc, e[31:0]);
      chk("R9 next pcs", fnpc ^ fnnpc, (e[31:0] + 32'd4) ^ (e[31:0] + 32'd8));
      chk("R9 redirect", {31'd0, redirect}, 32'h1);
      rd(3'd1, v);
      chk("R5 code", {27'd0, v[6:2]}, {27'd0, e[36:32]});
      chk("R3 slot flag", {31'd0, v[31]}, {31'd0, e[37]});
      chk("R4 cop field clear", {30'd0, v[29:28]}, 32'h0);
      rd(3'd2, v);
      chk("R3 epc", v, e[37] ? p - 32'd4 : p);
      rd(3'd0, v);
      chk("R2 exl", {31'd0, v[1]}, 32'h1);
    end

    // R9 one-cycle pulse
    @(negedge clk);
    chk("R9 redirect drops", {31'd0, redirect}, 32'h0);

    // R1 shadow swap, then hold with EXL set
    wr(3'd0, 32'h0);
    wr(3'd6, 32'h0000_5002);
    take(4'd8, 32'h200, 32'h204, 32'h0, 8'h0, 2'd0);
    rd(3'd6, v); chk("R1 swap", v, 32'h0000_5085);
    take(4'd8, 32'h300, 32'h304, 32'h0, 8'h0, 2'd0);
    rd(3'd6, v); chk("R1 hold with exl", v, 32'h0000_5085);

    // R4 coprocessor field
    wr(3'd1, 32'h0);
    take(4'd11, 32'h400, 32'h404, 32'h0, 8'h0, 2'd2);
    rd(3'd1, v); chk("R4 cop unusable cause", v, 32'h2000_002C);

    // R10 TLB registers
    wr(3'd5, 32'h0);
    take(4'd2, 32'h500, 32'h504, 32'h1234_5678, 8'h3C, 2'd0);
    rd(3'd3, v); chk("R10 bad address", v, 32'h1234_5678);
    rd(3'd4, v); chk("R10 entry high", v, 32'h1234_403C);
    rd(3'd5, v); chk("R10 context", v, 32'h0009_1A20);
    take(4'd8, 32'h600, 32'h604, 32'hFFFF_0000, 8'h55, 2'd0);
    rd(3'd3, v); chk("R10 syscall keeps bad address", v, 32'h1234_5678);
    rd(3'd4, v); chk("R10 syscall keeps entry high", v, 32'h1234_403C);
    rd(3'd5, v); chk("R10 syscall keeps context", v, 32'h0009_1A20);

    // R11 soft reset beats exception
    wr(3'd0, 32'h0);
    wr(3'd2, 32'h0000_0111);
    @(negedge clk);
    soft_rst = 1'b1; exc_valid = 1'b1; exc_kind = 4'd8; pc = 32'h700; npc = 32'h704;
    @(negedge clk);
    soft_rst = 1'b0; exc_valid = 1'b0;
    chk("R11 fetch pc", fpc, 32'hBFC0_0000);
    chk("R11 fetch npc", fnpc, 32'hBFC0_0004);
    rd(3'd0, v); chk("R11 status", v, 32'h2040_0000);
    rd(3'd2, v); chk("R11 epc untouched", v, 32'h0000_0111);

    // R13 write, base alignment, exception over write
    wr(3'd7, 32'h9000_0ABC);
    rd(3'd7, v); chk("R13 base write", v, 32'h9000_0000);
    @(negedge clk);
    we = 1'b1; sel = 3'd2; wdata = 32'h0000_DEAD;
    exc_valid = 1'b1; exc_kind = 4'd8; pc = 32'h2000; npc = 32'h2004;
    @(negedge clk);
    we = 1'b0; exc_valid = 1'b0;
    rd(3'd2, v); chk("R13 exception beats write", v, 32'h0000_2000);
    chk("R6 vector from new base", fpc, 32'h9000_0180);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule